// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines from peripherals. It presents a processor core with an 8-bit vector bus, a request wire and a separate non-maskable interrupt output. Software enables sources through a mask register. It can inspect the raw pending bits, the masked pending bits and the non-maskable status through a small 32-bit register port.

The controller does no priority arbitration. When a single enabled source is pending, the vector names that source directly, as 0x31 plus its pending-bit index. When several enabled sources are pending at once, the vector becomes the shared value 0x30. Software then reads the masked pending register and chooses which source to serve. Lines 30 and 31 never enter the maskable path. They only drive the non-maskable status bits and the non-maskable output.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `vec_o`, `req_o`, `nmi_o` and `rvalid_o` are low.
- R2: Line n, for n from 1 to 29, sets bit n-1 of the raw pending register (byte address 0x04) while it is high and clears it while it is low. Line 0 changes no register and no output. Raw bits 29 to 31 are always zero.
- R3: The mask register (byte address 0x00) is written by a word write. A write to any other address leaves every register unchanged.
- R4: The masked pending register (byte address 0x08) always equals the raw pending register ANDed with the mask register.
- R5: The vector is 0 when no masked bit in positions 0 to 30 is set. It is 0x31+i when exactly one masked bit i is set. It is 0x30 when two or more are set.
- R6: `req_o` is high exactly when `vec_o` is nonzero.
- R7: Lines 30 and 31 drive bits 30 and 31 of the non-maskable status register (byte address 0x0C), following their level. `nmi_o` is high whenever any status bit is set. The mask has no effect on these bits or on `nmi_o`.
- R8: The raw, masked and status registers and the `vec_o`, `req_o` and `nmi_o` outputs change at the same rising edge that samples an input change or accepts a mask write, and not before that edge.
- R9: A read strobe gives `rvalid_o` high with `rdata_o` on the next cycle. The data are the register values from before that edge. Byte address 0x10 (reserved), any address above it and any address with nonzero low two bits read zero.
- R10: An access with `be_i` other than 4'hF is ignored: a write changes nothing, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 32 | Level-sensitive request lines; 30 and 31 are non-maskable |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables; only 4'hF is accepted |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| vec_o | output | 8 | Interrupt vector, 0 when idle |
| req_o | output | 1 | Interrupt request to the core |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
A corrupted mask or raw pending bit shows at the ports on the cycle after the triggering edge. It appears as a wrong vector, for example a per-source code where the shared code 0x30 is due, or as a request when no enabled source is pending. It also appears in the next read of offsets 0x00, 0x04 or 0x08. A stale non-maskable status bit holds `nmi_o` high after the line falls, which is visible one edge later. The bench drives random line patterns and masks, including sparse one-hot patterns that reach every per-source code. It compares all outputs after every edge and reads back registers at random.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned IVC_DW = 32;
  localparam int unsigned IVC_VW = 8;

  typedef enum logic [2:0] {
    REG_MASK   = 3'd0,
    REG_RAW    = 3'd1,
    REG_MASKED = 3'd2,
    REG_NMI    = 3'd3,
    REG_RSVD   = 3'd4
  } ivc_reg_e;

  // Vector selection: none -> 0, single bit i -> base+i, several -> shared.
  function automatic logic [IVC_VW-1:0] ivc_pick_vector(
    input logic [IVC_DW-1:0] m,
    input int unsigned       search,
    input logic [IVC_VW-1:0] base,
    input logic [IVC_VW-1:0] shared
  );
    int unsigned       hits;
    logic [IVC_VW-1:0] first;
    hits  = 0;
    first = '0;
    for (int unsigned i = 0; i < IVC_DW; i++) begin
      if (i < search && m[i]) begin
        if (hits == 0) first = base + IVC_VW'(i);
        hits++;
      end
    end
    if (hits == 0)      return '0;
    else if (hits == 1) return first;
    else                return shared;
  endfunction

  // Only full-word, aligned accesses are honoured.
  function automatic logic ivc_word_access(input logic [3:0] be, input logic [1:0] lo);
    return (be == 4'hF) && (lo == 2'b00);
  endfunction
endpackage

// File: rtl/ivc_line_sampler.sv
module ivc_line_sampler
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned NMI_FIRST = 30
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [IVC_DW-1:0]    raw_d_o,
  output logic [IVC_DW-1:0]    raw_q_o,
  output logic [IVC_DW-1:0]    nmi_q_o,
  output logic                 nmi_o
);
  logic [IVC_DW-1:0] nmi_d;
  logic              unused_line0;

  assign unused_line0 = lines_i[0];

  for (genvar b = 0; b < IVC_DW; b++) begin : g_bit
    if (b + 1 < NMI_FIRST) begin : g_raw
      assign raw_d_o[b] = lines_i[b+1];
    end else begin : g_raw_zero
      assign raw_d_o[b] = 1'b0;
    end
    if (b >= NMI_FIRST && b < NUM_LINES) begin : g_nmi
      assign nmi_d[b] = lines_i[b];
    end else begin : g_nmi_zero
      assign nmi_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q_o <= '0;
      nmi_q_o <= '0;
      nmi_o   <= 1'b0;
    end else begin
      raw_q_o <= raw_d_o;
      nmi_q_o <= nmi_d;
      nmi_o   <= |nmi_d;
    end
  end
endmodule

// File: rtl/ivc_regbus.sv
module ivc_regbus
  import ivc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IVC_DW-1:0] wdata_i,
  input  logic [3:0]        be_i,
  input  logic [IVC_DW-1:0] raw_q_i,
  input  logic [IVC_DW-1:0] masked_q_i,
  input  logic [IVC_DW-1:0] nmi_q_i,
  output logic [IVC_DW-1:0] mask_q_o,
  output logic [IVC_DW-1:0] mask_d_o,
  output logic              mask_wr_hit_o,
  output logic [IVC_DW-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             word_ok;
  logic [IDX_W-1:0] idx;
  logic [IVC_DW-1:0] rd_mux;

  assign word_ok       = ivc_word_access(be_i, addr_i[1:0]);
  assign idx           = addr_i[ADDR_W-1:2];
  assign mask_wr_hit_o = wr_en_i && word_ok && (idx == IDX_W'(REG_MASK));
  assign mask_d_o      = mask_wr_hit_o ? wdata_i : mask_q_o;

  always_comb begin
    rd_mux = '0;
    if (word_ok) begin
      case (idx)
        IDX_W'(REG_MASK):   rd_mux = mask_q_o;
        IDX_W'(REG_RAW):    rd_mux = raw_q_i;
        IDX_W'(REG_MASKED): rd_mux = masked_q_i;
        IDX_W'(REG_NMI):    rd_mux = nmi_q_i;
        default:            rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      mask_q_o <= mask_d_o;
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/ivc_vector_unit.sv
module ivc_vector_unit
  import ivc_pkg::*;
#(
  parameter int unsigned       SEARCH_BITS = 31,
  parameter logic [IVC_VW-1:0] BASE_VEC    = 8'h31,
  parameter logic [IVC_VW-1:0] SHARED_VEC  = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IVC_DW-1:0] raw_d_i,
  input  logic [IVC_DW-1:0] mask_d_i,
  output logic [IVC_DW-1:0] masked_q_o,
  output logic [IVC_VW-1:0] vec_o,
  output logic              req_o
);
  logic [IVC_DW-1:0] masked_d;
  logic [IVC_DW-1:0] search_win;

  assign masked_d = raw_d_i & mask_d_i;

  for (genvar b = 0; b < IVC_DW; b++) begin : g_win
    if (b < SEARCH_BITS) begin : g_in
      assign search_win[b] = masked_d[b];
    end else begin : g_out
      assign search_win[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      masked_q_o <= '0;
      vec_o      <= '0;
      req_o      <= 1'b0;
    end else begin
      masked_q_o <= masked_d;
      vec_o      <= ivc_pick_vector(masked_d, SEARCH_BITS, BASE_VEC, SHARED_VEC);
      req_o      <= |search_win;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned NMI_FIRST   = 30,
  parameter int unsigned SEARCH_BITS = 31,
  parameter int unsigned ADDR_W      = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [IVC_DW-1:0]    wdata_i,
  input  logic [3:0]           be_i,
  output logic [IVC_DW-1:0]    rdata_o,
  output logic                 rvalid_o,
  output logic [IVC_VW-1:0]    vec_o,
  output logic                 req_o,
  output logic                 nmi_o
);
  logic [IVC_DW-1:0] raw_d, raw_q, nmi_q, mask_q, mask_d, masked_q;
  logic              mask_wr_hit;

  ivc_line_sampler #(.NUM_LINES(NUM_LINES), .NMI_FIRST(NMI_FIRST)) u_sampler (
    .clk_i, .rst_ni, .lines_i(irq_lines_i),
    .raw_d_o(raw_d), .raw_q_o(raw_q), .nmi_q_o(nmi_q), .nmi_o(nmi_o)
  );

  ivc_regbus #(.ADDR_W(ADDR_W)) u_regbus (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .be_i,
    .raw_q_i(raw_q), .masked_q_i(masked_q), .nmi_q_i(nmi_q),
    .mask_q_o(mask_q), .mask_d_o(mask_d), .mask_wr_hit_o(mask_wr_hit),
    .rdata_o, .rvalid_o
  );

  ivc_vector_unit #(.SEARCH_BITS(SEARCH_BITS)) u_vector (
    .clk_i, .rst_ni, .raw_d_i(raw_d), .mask_d_i(mask_d),
    .masked_q_o(masked_q), .vec_o, .req_o
  );
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              rvalid_o,
  input logic [IVC_VW-1:0] vec_o,
  input logic              req_o,
  input logic              nmi_o,
  input logic [IVC_DW-1:0] mask_q,
  input logic [IVC_DW-1:0] raw_q,
  input logic [IVC_DW-1:0] masked_q,
  input logic [IVC_DW-1:0] nmi_q,
  input logic              mask_wr_hit
);
  assert_req_vec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o == (vec_o != '0));

  assert_masked_and_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_q == (raw_q & mask_q));

  assert_shared_vec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(masked_q[30:0]) > 1) |-> (vec_o == 8'h30));

  assert_single_vec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(masked_q[30:0]) == 1) |-> (vec_o >= 8'h31 && vec_o <= 8'h4F));

  assert_idle_vec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_q[30:0] == '0) |-> (vec_o == '0));

  assert_nmi_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o == (nmi_q != '0));

  assert_nmi_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q[29:0] == '0);

  assert_raw_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_q[31:29] == 3'b000);

  assert_rvalid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);

  assert_rvalid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);

  assert_mask_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr_hit |=> $stable(mask_q));
endmodule

bind irq_vector_ctrl ivc_checker u_ivc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rvalid_o(rvalid_o),
  .vec_o(vec_o), .req_o(req_o), .nmi_o(nmi_o), .mask_q(mask_q),
  .raw_q(raw_q), .masked_q(masked_q), .nmi_q(nmi_q), .mask_wr_hit(mask_wr_hit)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] rdata;
  logic        rvalid;
  logic [7:0]  vec;
  logic        req, nmi;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_mask = '0, m_lines = '0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(irq), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .rvalid_o(rvalid),
    .vec_o(vec), .req_o(req), .nmi_o(nmi)
  );

  function automatic logic [31:0] f_raw(input logic [31:0] l);
    logic [31:0] r = '0;
    for (int i = 1; i <= 29; i++) r[i-1] = l[i];
    return r;
  endfunction

  function automatic logic [31:0] f_nmi(input logic [31:0] l);
    return {l[31], l[30], 30'd0};
  endfunction

  function automatic logic [7:0] f_vec(input logic [31:0] m);
    logic [31:0] w = {1'b0, m[30:0]};
    if (w == 0) return 8'h00;
    if ((w & (w - 1)) != 0) return 8'h30;
    for (int i = 0; i < 31; i++) if (w[i]) return 8'h31 + 8'(i);
    return 8'h00;
  endfunction

  function automatic logic [31:0] f_reg(input logic [4:0] a, input logic [3:0] b);
    if (b != 4'hF || a[1:0] != 0) return '0;
    case (a[4:2])
      3'd0: return m_mask;
      3'd1: return f_raw(m_lines);
      3'd2: return f_raw(m_lines) & m_mask;
      3'd3: return f_nmi(m_lines);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic chk_out(input string rq);
    logic [7:0] ev = f_vec(f_raw(m_lines) & m_mask);
    chk(rq, "vec", 32'(vec), 32'(ev));
    chk("R6", "req", 32'(req), 32'(ev != 0));
    chk("R7", "nmi", 32'(nmi), 32'(f_nmi(m_lines) != 0));
  endtask

  task automatic set_lines(input logic [31:0] v, input string rq);
    @(negedge clk);
    irq = v; m_lines = v;
    @(posedge clk); #1;
    chk_out(rq);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; be = b;
    if (b == 4'hF && a == 5'd0) m_mask = d;
    @(posedge clk); #1;
    wr_en = 1'b0; be = 4'hF;
    chk_out("R8");
  endtask

  task automatic rd_chk(input string rq, input logic [4:0] a, input logic [3:0] b);
    logic [31:0] exp = f_reg(a, b);
    @(negedge clk);
    rd_en = 1'b1; addr = a; be = b;
    @(posedge clk); #1;
    rd_en = 1'b0; be = 4'hF;
    chk("R9", "rvalid", 32'(rvalid), 32'd1);
    chk(rq, "rdata", rdata, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h1C0DE);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "vec at reset", 32'(vec), 0);
    chk("R1", "req at reset", 32'(req), 0);
    chk("R1", "nmi at reset", 32'(nmi), 0);
    chk("R1", "rvalid at reset", 32'(rvalid), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 5; a++) rd_chk("R1", 5'(a * 4), 4'hF);

    // R2: line 0 alone has no effect
    wr(5'h00, 32'hFFFF_FFFF, 4'hF);
    set_lines(32'h0000_0001, "R2");
    rd_chk("R2", 5'h04, 4'hF);
    rd_chk("R2", 5'h08, 4'hF);
    // R5: single source, line 5 -> bit 4 -> 0x35
    set_lines(32'h0000_0020, "R5");
    chk("R5", "single vec", 32'(vec), 32'h35);
    // R5: two sources -> shared
    set_lines(32'h2000_0002, "R5");
    chk("R5", "shared vec", 32'(vec), 32'h30);
    // R4/R5: mask leaves only bit 28 -> 0x4D
    wr(5'h00, 32'h1000_0000, 4'hF);
    chk("R5", "top source vec", 32'(vec), 32'h4D);
    rd_chk("R4", 5'h08, 4'hF);
    // R8: output not changed before the sampling edge
    @(negedge clk); irq = 32'h0; m_lines = 32'h0; #1;
    chk("R8", "vec before edge", 32'(vec), 32'h4D);
    @(posedge clk); #1;
    chk("R8", "vec after edge", 32'(vec), 32'h00);
    // R3: writes elsewhere are ignored
    wr(5'h04, 32'hDEAD_BEEF, 4'hF);
    wr(5'h10, 32'h1234_5678, 4'hF);
    rd_chk("R3", 5'h00, 4'hF);
    rd_chk("R3", 5'h04, 4'hF);
    // R10: partial byte enables ignored
    wr(5'h00, 32'h0000_00FF, 4'h1);
    rd_chk("R10", 5'h00, 4'hF);
    rd_chk("R10", 5'h00, 4'h3);
    // R9: reserved, beyond, misaligned
    rd_chk("R9", 5'h10, 4'hF);
    rd_chk("R9", 5'h14, 4'hF);
    rd_chk("R9", 5'h01, 4'hF);
    // R7: non-maskable lines with mask cleared
    wr(5'h00, 32'h0, 4'hF);
    set_lines(32'h4000_0000, "R7");
    chk("R7", "nmi line30", 32'(nmi), 1);
    rd_chk("R7", 5'h0C, 4'hF);
    set_lines(32'h8000_0000, "R7");
    rd_chk("R7", 5'h0C, 4'hF);
    rd_chk("R7", 5'h04, 4'hF);
    set_lines(32'h0, "R7");
    chk("R7", "nmi cleared", 32'(nmi), 0);

    for (int k = 0; k < 600; k++) begin
      case ($urandom % 5)
        0: wr(5'h00, $urandom, 4'hF);
        1: wr(5'h00, 32'h1 << ($urandom % 31), 4'hF);
        2: set_lines($urandom, "R2");
        3: set_lines((32'h1 << ($urandom % 32)) | ((($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0), "R5");
        default: rd_chk("R4", 5'($urandom % 24), (($urandom % 6) == 0) ? 4'h7 : 4'hF);
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule